// File: doc/BRIEF.md
# Palette and LCD Pixel Formatter

This block turns pixel words read from display memory into the colour word that drives an LCD panel. Pixels stored at 4 or 8 bits per pixel are pseudo-colour: the pixel value indexes a 256-entry colour table whose entries hold 4 bits each of red, green and blue, so 16 or 256 colours out of 4096 can appear at once. Pixels stored at 16 bits per pixel are direct colour, unpacked in one of two ways. On an STN panel the low 12 bits carry red, green and blue at 4 bits each. On a TFT panel the word is a 5-6-5 red-green-blue packing.

Each cycle the display side presents one pixel word with a valid flag, the pixel depth, a panel-type select and a TFT output-width select. One cycle later the formatted colour appears with its own valid flag. The colour is either a 12-bit 4-4-4 word or, for a TFT panel set to the wide output, a 16-bit 5-6-5 word. A host port writes the colour table at any time. Such a write is never held off by display traffic: a pixel read in the same cycle gets the old entry, and the next pixel gets the new one.

Top module: `pal_lcd_formatter`

## Requirements
- R1: After reset `out_valid_o` and `out_color_o` are 0 and every colour-table entry reads as 0.
- R2: `out_valid_o` is `pix_valid_i` delayed by exactly one clock, and the colour belongs to that same pixel. While `out_valid_o` is low, `out_color_o` is 0.
- R3: With `depth_i` = 2'b01 (4 bpp) the table index is `pix_data_i[3:0]`, so only entries 0 to 15 are reachable; bits 15:4 have no effect.
- R4: With `depth_i` = 2'b10 (8 bpp) the table index is `pix_data_i[7:0]`; bits 15:8 have no effect.
- R5: A table entry is written as `host_color_i`, with red in bits 11:8, green in 7:4 and blue in 3:0. In the narrow output the entry appears unchanged in `out_color_o[11:0]`, and `out_color_o[15:12]` is 0. An STN panel (`panel_tft_i` = 0) always gets the narrow output, whatever `out_wide_i` is.
- R6: With `panel_tft_i` = 1 and `out_wide_i` = 1 the output is 5-6-5: red in 15:11, green in 10:5, blue in 4:0. A table colour is widened by appending the channel's top bits: red {r,r[3]}, green {g,g[3:2]}, blue {b,b[3]}.
- R7: With `depth_i` = 2'b11 (16 bpp) on an STN panel the output is {4'b0, `pix_data_i[11:0]`}; bits 15:12 of the pixel have no effect.
- R8: At 16 bpp on a TFT panel with the wide output, `out_color_o` equals the pixel word unchanged.
- R9: At 16 bpp on a TFT panel with the narrow output, the output is {4'b0, pix[15:12], pix[10:7], pix[4:1]}, the top 4 bits of each 5-6-5 field.
- R10: A host write (`host_wr_i` = 1) commits whether or not a pixel is present. A pixel in the same cycle that reads the same entry gets the previous contents, and any later pixel gets the new contents.
- R11: `depth_i` = 2'b00 is reserved: the pixel still produces `out_valid_o`, with `out_color_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel word present this cycle |
| pix_data_i | input | 16 | Pixel word from display memory |
| depth_i | input | 2 | Pixel depth: 00 reserved, 01 4 bpp, 10 8 bpp, 11 16 bpp |
| panel_tft_i | input | 1 | 1 = TFT panel, 0 = STN panel |
| out_wide_i | input | 1 | TFT output width: 1 = 5-6-5, 0 = 4-4-4 |
| host_wr_i | input | 1 | Colour-table write strobe |
| host_idx_i | input | 8 | Colour-table entry to write |
| host_color_i | input | 12 | Colour to store (R 11:8, G 7:4, B 3:0) |
| out_valid_o | output | 1 | Formatted colour present |
| out_color_o | output | 16 | Formatted colour, 4-4-4 in bits 11:0 or 5-6-5 |

## Verification
The bench sends 4 bpp and 8 bpp pixels with junk in their upper bits. A design that indexed the table with too many bits would return an entry other than the intended one. A pixel that reads an entry in the same cycle the host rewrites it must return the old value, and the pixel right after must return the new one; a write that bypassed into the read, or landed a cycle late, shows up as a wrong colour. The bench drives the wide TFT output with table colours whose channel top bits differ, so zero-fill or the wrong bits appended would give a mismatch. It also covers both 16-bpp unpackings, an STN panel with the wide select set, and the reserved depth code, with back-to-back pixels as well as gaps, so that a valid flag out of step with its colour is caught.

// File: rtl/pal_fmt_pkg.sv
package pal_fmt_pkg;

    localparam int CH_W    = 4;
    localparam int COLOR_W = 3 * CH_W;
    localparam int OUT_W   = 16;

    typedef enum logic [1:0] {
        DEPTH_RSVD = 2'b00,
        DEPTH_4    = 2'b01,
        DEPTH_8    = 2'b10,
        DEPTH_16   = 2'b11
    } depth_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb444_t;

endpackage

// File: rtl/pal_lut.sv
module pal_lut #(
    parameter int IDX_W = 8,
    parameter int DAT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DAT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DAT_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DAT_W-1:0] mem [DEPTH];
    logic [1:0]       age;

    // Write and read share an edge: the read returns the prior contents.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) mem[wr_idx] <= wr_data;
            rd_data <= mem[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    // R10: a write is visible to the first read after it.
    assert_write_then_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(wr_en) && rd_idx == $past(wr_idx))
        |=> rd_data == $past(wr_data, 2));

endmodule

// File: rtl/pal_widen.sv
module pal_widen
    import pal_fmt_pkg::*;
(
    input  rgb444_t           color_i,
    input  logic              wide_i,
    output logic [OUT_W-1:0]  color_o
);
    always_comb begin
        if (wide_i)
            color_o = {color_i.r, color_i.r[CH_W-1],
                       color_i.g, color_i.g[CH_W-1 -: 2],
                       color_i.b, color_i.b[CH_W-1]};
        else
            color_o = {{(OUT_W-COLOR_W){1'b0}}, color_i};
    end
endmodule

// File: rtl/pal_direct_unpack.sv
module pal_direct_unpack
    import pal_fmt_pkg::*;
(
    input  logic [OUT_W-1:0] pix_i,
    input  logic             tft_i,
    input  logic             wide_i,
    output logic [OUT_W-1:0] color_o
);
    localparam int PAD = OUT_W - COLOR_W;

    always_comb begin
        if (!tft_i)
            color_o = {{PAD{1'b0}}, pix_i[COLOR_W-1:0]};
        else if (wide_i)
            color_o = pix_i;
        else
            color_o = {{PAD{1'b0}}, pix_i[15:12], pix_i[10:7], pix_i[4:1]};
    end
endmodule

// File: rtl/pal_lcd_formatter.sv
module pal_lcd_formatter
    import pal_fmt_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid_i,
    input  logic [15:0]       pix_data_i,
    input  logic [1:0]        depth_i,
    input  logic              panel_tft_i,
    input  logic              out_wide_i,
    input  logic              host_wr_i,
    input  logic [IDX_W-1:0]  host_idx_i,
    input  logic [11:0]       host_color_i,
    output logic              out_valid_o,
    output logic [15:0]       out_color_o
);
    localparam int NIB = 4;

    logic [IDX_W-1:0] rd_idx;
    logic [11:0]      lut_q;
    logic             valid_q;
    depth_e           depth_q;
    logic             tft_q;
    logic             wide_q;
    logic [15:0]      data_q;
    logic [15:0]      pal_color;
    logic [15:0]      dir_color;

    always_comb begin
        if (depth_e'(depth_i) == DEPTH_4)
            rd_idx = {{(IDX_W-NIB){1'b0}}, pix_data_i[NIB-1:0]};
        else
            rd_idx = pix_data_i[IDX_W-1:0];
    end

    pal_lut #(.IDX_W(IDX_W), .DAT_W(COLOR_W)) u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr_i),
        .wr_idx  (host_idx_i),
        .wr_data (host_color_i),
        .rd_idx  (rd_idx),
        .rd_data (lut_q)
    );

    // Stage register, aligned with the table read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            depth_q <= DEPTH_RSVD;
            tft_q   <= 1'b0;
            wide_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= pix_valid_i;
            depth_q <= depth_e'(depth_i);
            tft_q   <= panel_tft_i;
            wide_q  <= panel_tft_i & out_wide_i;
            data_q  <= pix_data_i;
        end
    end

    pal_widen u_widen (
        .color_i (rgb444_t'(lut_q)),
        .wide_i  (wide_q),
        .color_o (pal_color)
    );

    pal_direct_unpack u_unpack (
        .pix_i   (data_q),
        .tft_i   (tft_q),
        .wide_i  (wide_q),
        .color_o (dir_color)
    );

    always_comb begin
        out_valid_o = valid_q;
        out_color_o = '0;
        if (valid_q) begin
            unique case (depth_q)
                DEPTH_4, DEPTH_8: out_color_o = pal_color;
                DEPTH_16:         out_color_o = dir_color;
                default:          out_color_o = '0;
            endcase
        end
    end

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> out_valid_o);
    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> (!out_valid_o && out_color_o == 16'h0));
    assert_stn_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && depth_i == 2'b11 && !panel_tft_i)
        |=> out_color_o == {4'h0, $past(pix_data_i[11:0])});
    assert_tft_wide_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && depth_i == 2'b11 && panel_tft_i && out_wide_i)
        |=> out_color_o == $past(pix_data_i));
    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && depth_i == 2'b00) |=> (out_valid_o && out_color_o == 16'h0));
    assert_widen_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_i && depth_i[1] != depth_i[0] && panel_tft_i && out_wide_i)
        |=> (out_color_o[11] == out_color_o[15] && out_color_o[6:5] == out_color_o[10:9]
             && out_color_o[0] == out_color_o[4]));

endmodule

// File: tb/pal_lcd_formatter_bench.sv
`timescale 1ns/1ps
module pal_lcd_formatter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic [15:0] pix_data_i = '0;
    logic [1:0]  depth_i = '0;
    logic        panel_tft_i = 1'b0;
    logic        out_wide_i = 1'b0;
    logic        host_wr_i = 1'b0;
    logic [7:0]  host_idx_i = '0;
    logic [11:0] host_color_i = '0;
    logic        out_valid_o;
    logic [15:0] out_color_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] pal_m [256];
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    pal_lcd_formatter u_pal_lcd_formatter (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
        .depth_i(depth_i), .panel_tft_i(panel_tft_i), .out_wide_i(out_wide_i),
        .host_wr_i(host_wr_i), .host_idx_i(host_idx_i), .host_color_i(host_color_i),
        .out_valid_o(out_valid_o), .out_color_o(out_color_o)
    );

    function automatic logic [15:0] expect_color(input logic [1:0] d, input logic t,
                                                  input logic w, input logic [15:0] px);
        logic [11:0] e;
        logic [3:0]  r, g, b;
        if (d == 2'b01 || d == 2'b10) begin
            e = (d == 2'b01) ? pal_m[{4'h0, px[3:0]}] : pal_m[px[7:0]];
            r = e[11:8]; g = e[7:4]; b = e[3:0];
            if (t && w) return {r, r[3], g, g[3], g[2], b, b[3]};
            return {4'h0, e};
        end
        if (d == 2'b11) begin
            if (!t) return {4'h0, px[11:0]};
            if (w)  return px;
            return {4'h0, px[15:12], px[10:7], px[4:1]};
        end
        return 16'h0;
    endfunction

    function automatic logic [11:0] fill_val(input int i);
        return 12'((i * 173 + 677) % 4096);
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] d, input logic t, input logic w,
                        input logic [15:0] px, input logic we, input logic [7:0] wi,
                        input logic [11:0] wc, input string tag);
        @(negedge clk);
        pix_valid_i = v; depth_i = d; panel_tft_i = t; out_wide_i = w; pix_data_i = px;
        host_wr_i = we; host_idx_i = wi; host_color_i = wc;
        if (v) begin
            exp_q.push_back(expect_color(d, t, w, px));
            tag_q.push_back(tag);
        end
        if (we) pal_m[wi] = wc;
    endtask

    task automatic pix(input logic [1:0] d, input logic t, input logic w,
                       input logic [15:0] px, input string tag);
        step(1'b1, d, t, w, px, 1'b0, 8'h0, 12'h0, tag);
    endtask

    task automatic idle();
        step(1'b0, 2'b00, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0, 12'h0, "");
    endtask

    // Monitor: outputs come only from registers, so the falling edge is safe.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected valid", out_color_o, 16'h0);
                end else begin
                    logic [15:0] e;
                    string tg;
                    e = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    check(out_color_o == e, tg, out_color_o, e);
                end
            end else if (out_color_o != 16'h0) begin
                check(1'b0, "R2 colour while idle", out_color_o, 16'h0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R2 watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) pal_m[i] = 12'h0;
        repeat (3) @(negedge clk);
        check(out_valid_o == 1'b0 && out_color_o == 16'h0, "R1 in reset",
              {15'h0, out_valid_o} | out_color_o, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid_o == 1'b0 && out_color_o == 16'h0, "R1 after reset",
              {15'h0, out_valid_o} | out_color_o, 16'h0);

        // R1: table is empty after reset
        pix(2'b10, 1'b0, 1'b0, 16'h0055, "R1 table cleared 8bpp");
        pix(2'b01, 1'b1, 1'b1, 16'h000C, "R1 table cleared 4bpp");
        idle();

        // R10: writes commit with no pixel present
        for (int i = 0; i < 256; i++)
            step(1'b0, 2'b00, 1'b0, 1'b0, 16'h0, 1'b1, 8'(i), fill_val(i), "");
        idle();

        // R3: 4 bpp, junk in bits 15:4
        for (int i = 0; i < 16; i++)
            pix(2'b01, 1'b0, 1'b0, {12'(i * 311 + 4000), 4'(i)}, "R3 4bpp index");
        pix(2'b01, 1'b1, 1'b0, 16'hFFF5, "R3 4bpp TFT narrow");
        idle();
        // R4: 8 bpp, junk in bits 15:8
        for (int i = 0; i < 32; i++)
            pix(2'b10, 1'b0, 1'b0, {8'(i * 7 + 200), 8'(i * 37 + 11)}, "R4 8bpp index");
        idle();
        // R5: STN ignores the wide select
        pix(2'b10, 1'b0, 1'b1, 16'h00A7, "R5 STN stays narrow");
        pix(2'b01, 1'b0, 1'b1, 16'h0003, "R5 STN stays narrow 4bpp");
        pix(2'b10, 1'b1, 1'b0, 16'h0042, "R5 TFT narrow palette");
        // R6: widening with channel top bits that differ
        step(1'b0, 2'b00, 1'b0, 1'b0, 16'h0, 1'b1, 8'h10, 12'h8F3, "");
        step(1'b0, 2'b00, 1'b0, 1'b0, 16'h0, 1'b1, 8'h11, 12'h74C, "");
        pix(2'b10, 1'b1, 1'b1, 16'h0010, "R6 widen 8F3");
        pix(2'b10, 1'b1, 1'b1, 16'h0011, "R6 widen 74C");
        for (int i = 0; i < 16; i++)
            pix(2'b01, 1'b1, 1'b1, 16'(i), "R6 widen 4bpp");
        idle();
        // R7..R9: direct colour
        pix(2'b11, 1'b0, 1'b0, 16'hFABC, "R7 STN 16bpp");
        pix(2'b11, 1'b0, 1'b1, 16'h5123, "R7 STN 16bpp wide select");
        pix(2'b11, 1'b1, 1'b1, 16'hF81F, "R8 TFT 16bpp wide");
        pix(2'b11, 1'b1, 1'b1, 16'h07E0, "R8 TFT 16bpp wide");
        pix(2'b11, 1'b1, 1'b0, 16'hF81F, "R9 TFT 16bpp narrow");
        pix(2'b11, 1'b1, 1'b0, 16'h8421, "R9 TFT 16bpp narrow");
        idle();
        // R11: reserved depth
        pix(2'b00, 1'b1, 1'b1, 16'hFFFF, "R11 reserved depth");
        pix(2'b00, 1'b0, 1'b0, 16'h1234, "R11 reserved depth");
        // R10: same-cycle write and read, then the next pixel
        step(1'b1, 2'b10, 1'b0, 1'b0, 16'h0020, 1'b1, 8'h20, 12'hD61, "R10 old entry same cycle");
        pix(2'b10, 1'b0, 1'b0, 16'h0020, "R10 new entry next pixel");
        step(1'b1, 2'b01, 1'b1, 1'b1, 16'h0007, 1'b1, 8'h07, 12'h3B9, "R10 old entry 4bpp");
        pix(2'b01, 1'b1, 1'b1, 16'h0007, "R10 new entry 4bpp");
        // R2: gaps and mixed modes back to back
        pix(2'b11, 1'b1, 1'b1, 16'hABCD, "R2 stream");
        idle();
        pix(2'b10, 1'b1, 1'b1, 16'h0099, "R2 stream");
        pix(2'b00, 1'b0, 1'b0, 16'h0099, "R2 stream");
        pix(2'b01, 1'b0, 1'b0, 16'h0099, "R2 stream");
        idle();
        idle();
        idle();
        check(exp_q.size() == 0, "R2 all outputs seen", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule